// File: doc/BRIEF.md
# Base-Plus-Delta Cache Line Codec

This block shrinks a 64-byte cache line of eight 64-bit words into a smaller encoded form when the line's values lie close together, and expands such a form back into the full line. The encoder treats word 0 as the base and subtracts it from every word. If every difference can be held in a narrow signed field, it emits the base followed by eight deltas of that width. If no width fits, it emits the line unchanged. A 2-bit form tag and the encoded size in bytes travel with every encoded payload.

The encoder side is a single-register stage. A line accepted on one clock edge is presented on the output from the next edge, and a new line can be taken on every cycle. The decoder side is purely combinational. It rebuilds all eight words at once by adding each sign-extended delta to the base, so a cache can place it on a latency-critical read path. Each side has its own valid/ready handshake.

Top module: `bdi_codec`

## Requirements
- R1: A line taken on a rising edge where `c_in_valid` and `c_in_ready` are both high appears with `c_out_valid` high from the next edge. `c_in_ready` is high out of reset exactly when `c_out_valid` is low or `c_out_ready` is high, so one line per cycle is sustained.
- R2: While `c_out_valid` is high and `c_out_ready` is low, `c_out_valid`, `c_out_tag`, `c_out_size` and `c_out_payload` hold their values.
- R3: The encoder picks the narrowest delta width among 1, 2 and 4 bytes for which every (word minus word 0), taken modulo 2^64, equals the sign extension of its low 8, 16 or 32 bits. The tag is 0 for 1-byte, 1 for 2-byte and 2 for 4-byte deltas.
- R4: A line that fits no delta width gets tag 3, and its payload is the input line bit for bit.
- R5: In a delta form, payload bits [63:0] hold word 0, and delta i (i = 0..7, width W bits) sits at bits [64+i*W +: W]. All payload bits above 64+8*W are zero.
- R6: `c_out_size` is 16, 24 or 40 for tags 0, 1 and 2, and 64 for tag 3.
- R7: An all-zero line is encoded with tag 0, size 16 and an all-zero payload.
- R8: The decoder is combinational. `d_out_valid` follows `d_in_valid` and `d_in_ready` follows `d_out_ready` in the same cycle. For tags 0 to 2, word i of `d_out_line` equals payload bits [63:0] plus the sign-extended delta i, modulo 2^64. Any encoder output therefore decodes back to the original line.
- R9: For tag 3, `d_out_line` equals `d_in_payload`.
- R10: While `rst_n` is low, and for two edges after it rises, `c_out_valid` and `c_in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_in_valid | input | 1 | Line offered to the encoder |
| c_in_ready | output | 1 | Encoder can take a line |
| c_in_line | input | 512 | Line to encode, word i at bits [64*i +: 64] |
| c_out_valid | output | 1 | Encoded line available |
| c_out_ready | input | 1 | Consumer takes the encoded line |
| c_out_tag | output | 2 | Form tag |
| c_out_size | output | 7 | Encoded size in bytes |
| c_out_payload | output | 512 | Encoded payload |
| d_in_valid | input | 1 | Encoded line offered to the decoder |
| d_in_ready | output | 1 | Decoder can take it |
| d_in_tag | input | 2 | Form tag of the encoded line |
| d_in_payload | input | 512 | Encoded payload |
| d_out_valid | output | 1 | Rebuilt line available |
| d_out_ready | input | 1 | Consumer takes the rebuilt line |
| d_out_line | output | 512 | Rebuilt line |

## Verification
The encoder is exercised in several ways:
- Lines where a single word is moved from the base by an offset at each edge of a signed range (127/−128, 32767/−32768, 2^31−1/−2^31) and just past it. These show whether the width choice switches at exactly the right boundary.
- Bases near the top of the unsigned and signed ranges, whose differences only fit once arithmetic wraps. These separate true modulo subtraction from a magnitude compare.
- Ramps and random lines with 1-, 2- and 4-byte spreads, and fully random lines. These check that every form, the uncompressed fallback and the size field are produced.

Every encoded line is fed straight into the decoder and must come back unchanged. Random gaps on the input and random backpressure on the output show whether the handshake and the hold-under-stall behaviour are right.

// File: rtl/bdi_pkg.sv
package bdi_pkg;
  typedef enum logic [1:0] {
    FORM_D8  = 2'd0,
    FORM_D16 = 2'd1,
    FORM_D32 = 2'd2,
    FORM_RAW = 2'd3
  } form_e;

  localparam int NUM_DELTA_FORMS = 3;

  function automatic int form_payload_bits(input int word_w, input int words, input int delta_w);
    return word_w + words * delta_w;
  endfunction
endpackage

// File: rtl/bdi_form_enc.sv
module bdi_form_enc #(
  parameter int WORD_W  = 64,
  parameter int WORDS   = 8,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int USED_W = WORD_W + WORDS * DELTA_W
) (
  input  logic [LINE_W-1:0] line_i,
  output logic              fits_o,
  output logic [USED_W-1:0] payload_o
);
  logic [WORD_W-1:0] base;
  logic [WORDS-1:0]  word_ok;

  assign base = line_i[WORD_W-1:0];
  assign payload_o[WORD_W-1:0] = base;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0]  diff;
    logic [WORD_W-DELTA_W:0] upper;
    assign diff  = line_i[i*WORD_W +: WORD_W] - base;
    assign upper = diff[WORD_W-1:DELTA_W-1];
    // sign bit of delta plus all dropped bits must agree
    assign word_ok[i] = (&upper) | ~(|upper);
    assign payload_o[WORD_W + i*DELTA_W +: DELTA_W] = diff[DELTA_W-1:0];
  end

  assign fits_o = &word_ok;
endmodule

// File: rtl/bdi_form_dec.sv
module bdi_form_dec #(
  parameter int WORD_W  = 64,
  parameter int WORDS   = 8,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int USED_W = WORD_W + WORDS * DELTA_W
) (
  input  logic [USED_W-1:0] payload_i,
  output logic [LINE_W-1:0] line_o
);
  logic [WORD_W-1:0] base;
  assign base = payload_i[WORD_W-1:0];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DELTA_W-1:0] delta;
    logic [WORD_W-1:0]  delta_ext;
    assign delta     = payload_i[WORD_W + i*DELTA_W +: DELTA_W];
    assign delta_ext = {{(WORD_W-DELTA_W){delta[DELTA_W-1]}}, delta};
    assign line_o[i*WORD_W +: WORD_W] = base + delta_ext;
  end
endmodule

// File: rtl/bdi_decoder.sv
module bdi_decoder
  import bdi_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int DW0    = 8,
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic [1:0]        tag_i,
  input  logic [LINE_W-1:0] payload_i,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] form_line [NUM_DELTA_FORMS];

  for (genvar k = 0; k < NUM_DELTA_FORMS; k++) begin : g_form
    localparam int DW   = DW0 << k;
    localparam int USED = form_payload_bits(WORD_W, WORDS, DW);
    bdi_form_dec #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS),
      .DELTA_W(DW)
    ) u_dec (
      .payload_i(payload_i[USED-1:0]),
      .line_o   (form_line[k])
    );
  end

  always_comb begin
    unique case (form_e'(tag_i))
      FORM_D8:  line_o = form_line[0];
      FORM_D16: line_o = form_line[1];
      FORM_D32: line_o = form_line[2];
      default:  line_o = payload_i;
    endcase
  end
endmodule

// File: rtl/bdi_codec.sv
module bdi_codec
  import bdi_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int DW0    = 8,
  localparam int LINE_W     = WORD_W * WORDS,
  localparam int LINE_BYTES = LINE_W / 8,
  localparam int SIZE_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_in_valid,
  output logic              c_in_ready,
  input  logic [LINE_W-1:0] c_in_line,
  output logic              c_out_valid,
  input  logic              c_out_ready,
  output logic [1:0]        c_out_tag,
  output logic [SIZE_W-1:0] c_out_size,
  output logic [LINE_W-1:0] c_out_payload,
  input  logic              d_in_valid,
  output logic              d_in_ready,
  input  logic [1:0]        d_in_tag,
  input  logic [LINE_W-1:0] d_in_payload,
  output logic              d_out_valid,
  input  logic              d_out_ready,
  output logic [LINE_W-1:0] d_out_line
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // per-form encoders, all evaluated in parallel
  logic [NUM_DELTA_FORMS-1:0] form_fit;
  logic [LINE_W-1:0]          form_pl [NUM_DELTA_FORMS];
  logic [SIZE_W-1:0]          form_sz [NUM_DELTA_FORMS];

  for (genvar k = 0; k < NUM_DELTA_FORMS; k++) begin : g_form
    localparam int DW   = DW0 << k;
    localparam int USED = form_payload_bits(WORD_W, WORDS, DW);
    logic [USED-1:0] pk;
    bdi_form_enc #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS),
      .DELTA_W(DW)
    ) u_enc (
      .line_i   (c_in_line),
      .fits_o   (form_fit[k]),
      .payload_o(pk)
    );
    assign form_pl[k] = LINE_W'(pk);
    assign form_sz[k] = SIZE_W'(USED / 8);
  end

  // narrowest fitting form wins
  logic [1:0]        sel_tag;
  logic [SIZE_W-1:0] sel_size;
  logic [LINE_W-1:0] sel_pl;

  always_comb begin
    sel_tag  = FORM_RAW;
    sel_size = SIZE_W'(LINE_BYTES);
    sel_pl   = c_in_line;
    for (int k = NUM_DELTA_FORMS - 1; k >= 0; k--) begin
      if (form_fit[k]) begin
        sel_tag  = 2'(k);
        sel_size = form_sz[k];
        sel_pl   = form_pl[k];
      end
    end
  end

  // output stage
  logic              out_vld_q, out_vld_d;
  logic [1:0]        out_tag_q;
  logic [SIZE_W-1:0] out_size_q;
  logic [LINE_W-1:0] out_pl_q;
  logic              accept;

  always_comb begin
    c_in_ready = rst_n_int & (~out_vld_q | c_out_ready);
    accept     = c_in_valid & c_in_ready;
    out_vld_d  = accept | (out_vld_q & ~c_out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld_q <= 1'b0;
    else        out_vld_q <= out_vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_tag_q  <= sel_tag;
      out_size_q <= sel_size;
      out_pl_q   <= sel_pl;
    end
  end

  assign c_out_valid   = out_vld_q;
  assign c_out_tag     = out_tag_q;
  assign c_out_size    = out_size_q;
  assign c_out_payload = out_pl_q;

  // decoder: single combinational stage
  assign d_out_valid = d_in_valid;
  assign d_in_ready  = d_out_ready;

  bdi_decoder #(
    .WORD_W(WORD_W),
    .WORDS (WORDS),
    .DW0   (DW0)
  ) u_decoder (
    .tag_i    (d_in_tag),
    .payload_i(d_in_payload),
    .line_o   (d_out_line)
  );
endmodule

// File: rtl/bdi_codec_chk.sv
module bdi_codec_chk #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int DW0    = 8,
  localparam int LINE_W     = WORD_W * WORDS,
  localparam int LINE_BYTES = LINE_W / 8,
  localparam int SIZE_W     = $clog2(LINE_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_in_valid,
  input logic              c_in_ready,
  input logic [LINE_W-1:0] c_in_line,
  input logic              c_out_valid,
  input logic              c_out_ready,
  input logic [1:0]        c_out_tag,
  input logic [SIZE_W-1:0] c_out_size,
  input logic [LINE_W-1:0] c_out_payload,
  input logic              d_in_valid,
  input logic [1:0]        d_in_tag,
  input logic [LINE_W-1:0] d_in_payload,
  input logic [LINE_W-1:0] d_out_line
);
  logic              took;
  logic [SIZE_W-1:0] exp_size;

  assign took = c_in_valid & c_in_ready;

  always_comb begin
    if (c_out_tag == 2'd3) exp_size = SIZE_W'(LINE_BYTES);
    else exp_size = SIZE_W'((WORD_W + WORDS * (DW0 << c_out_tag)) / 8);
  end

  p_accept_next_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> c_out_valid);

  p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out_valid && !c_out_ready) |=>
      (c_out_valid && $stable(c_out_tag) && $stable(c_out_size) && $stable(c_out_payload)));

  p_base_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (c_out_payload[WORD_W-1:0] == $past(c_in_line[WORD_W-1:0])));

  p_raw_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ((c_out_tag != 2'd3) || (c_out_payload == $past(c_in_line))));

  p_size_matches_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_out_valid |-> (c_out_size == exp_size));

  p_zero_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (c_in_line == '0)) |=> ((c_out_tag == 2'd0) && (c_out_payload == '0)));

  p_raw_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_in_valid && (d_in_tag == 2'd3)) |-> (d_out_line == d_in_payload));
endmodule

bind bdi_codec bdi_codec_chk #(
  .WORD_W(WORD_W),
  .WORDS (WORDS),
  .DW0   (DW0)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .c_in_valid   (c_in_valid),
  .c_in_ready   (c_in_ready),
  .c_in_line    (c_in_line),
  .c_out_valid  (c_out_valid),
  .c_out_ready  (c_out_ready),
  .c_out_tag    (c_out_tag),
  .c_out_size   (c_out_size),
  .c_out_payload(c_out_payload),
  .d_in_valid   (d_in_valid),
  .d_in_tag     (d_in_tag),
  .d_in_payload (d_in_payload),
  .d_out_line   (d_out_line)
);

// File: tb/tb_bdi_codec.sv
module tb_bdi_codec;
  localparam int LW = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          c_in_valid, c_in_ready, c_out_valid, c_out_ready;
  logic [LW-1:0] c_in_line, c_out_payload, d_out_line;
  logic [1:0]    c_out_tag;
  logic [6:0]    c_out_size;
  logic          d_in_ready, d_out_valid, d_out_ready;

  bdi_codec dut (
    .clk(clk), .rst_n(rst_n),
    .c_in_valid(c_in_valid), .c_in_ready(c_in_ready), .c_in_line(c_in_line),
    .c_out_valid(c_out_valid), .c_out_ready(c_out_ready), .c_out_tag(c_out_tag),
    .c_out_size(c_out_size), .c_out_payload(c_out_payload),
    .d_in_valid(c_out_valid), .d_in_ready(d_in_ready), .d_in_tag(c_out_tag),
    .d_in_payload(c_out_payload), .d_out_valid(d_out_valid),
    .d_out_ready(d_out_ready), .d_out_line(d_out_line)
  );
  assign c_out_ready = d_in_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk_one(input logic [63:0] base, input int idx, input longint off);
    logic [LW-1:0] l;
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = base;
    l[idx*64 +: 64] = base + 64'(off);
    return l;
  endfunction

  function automatic logic [LW-1:0] mk_ramp(input logic [63:0] base, input longint step);
    logic [LW-1:0] l;
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = base + 64'(step * i);
    return l;
  endfunction

  function automatic logic [LW-1:0] mk_rand(input int kind);
    logic [LW-1:0] l;
    logic [63:0] base;
    longint off;
    base = {$urandom, $urandom};
    for (int i = 0; i < 8; i++) begin
      case (kind)
        0: off = longint'(int'($urandom_range(0, 255)) - 128);
        1: off = longint'(int'($urandom_range(0, 65535)) - 32768);
        2: off = longint'(int'($urandom));
        default: off = longint'({$urandom, $urandom});
      endcase
      l[i*64 +: 64] = (i == 0) ? base : base + 64'(off);
    end
    return l;
  endfunction

  // behavioural reference encoder
  task automatic ref_enc(input logic [LW-1:0] ln, output logic [1:0] tg,
                         output logic [6:0] sz, output logic [LW-1:0] pl);
    logic [63:0] base, d;
    longint sd, lim;
    bit ok;
    int dw;
    base = ln[63:0];
    tg = 2'd3; sz = 7'd64; pl = ln;
    for (int f = 2; f >= 0; f--) begin
      dw = 8 << f;
      lim = longint'(1) <<< (dw - 1);
      ok = 1;
      for (int i = 0; i < 8; i++) begin
        d = ln[i*64 +: 64] - base;
        sd = longint'(d);
        if (sd < -lim || sd >= lim) ok = 0;
      end
      if (ok) begin
        tg = 2'(f);
        sz = 7'(8 + dw);
        pl = '0;
        pl[63:0] = base;
        for (int i = 0; i < 8; i++) begin
          d = ln[i*64 +: 64] - base;
          for (int b = 0; b < dw; b++) pl[64 + i*dw + b] = d[b];
        end
      end
    end
  endtask

  logic [LW-1:0] stim_q[$];

  logic          m_vld;
  logic [LW-1:0] m_line, m_pl;
  logic [1:0]    m_tag;
  logic [6:0]    m_size;
  bit            prev_stall;
  logic [LW-1:0] prev_pl;
  logic [1:0]    prev_tag;
  logic [6:0]    prev_size;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit acc;
    rst_n = 1'b0; c_in_valid = 1'b0; c_in_line = '0; d_out_ready = 1'b0;
    m_vld = 0; prev_stall = 0; m_line = '0; m_pl = '0; m_tag = '0; m_size = '0;

    // directed patterns: width boundaries, wrapping, ramps, all-zero
    stim_q.push_back('0);
    stim_q.push_back(mk_one(64'h1234_5678_9abc_def0, 3, 127));
    stim_q.push_back(mk_one(64'h1234_5678_9abc_def0, 5, -128));
    stim_q.push_back(mk_one(64'h1234_5678_9abc_def0, 1, 128));
    stim_q.push_back(mk_one(64'h1234_5678_9abc_def0, 7, -129));
    stim_q.push_back(mk_one(64'h0000_0000_0000_1000, 2, 32767));
    stim_q.push_back(mk_one(64'h0000_0000_0000_1000, 4, -32768));
    stim_q.push_back(mk_one(64'h0000_0000_0000_1000, 6, 32768));
    stim_q.push_back(mk_one(64'h0000_0000_0000_1000, 6, -32769));
    stim_q.push_back(mk_one(64'hdead_beef_0000_0000, 1, 64'sh7fff_ffff));
    stim_q.push_back(mk_one(64'hdead_beef_0000_0000, 2, -64'sh8000_0000));
    stim_q.push_back(mk_one(64'hdead_beef_0000_0000, 3, 64'sh8000_0000));
    stim_q.push_back(mk_one(64'hffff_ffff_ffff_ffff, 2, 1));
    stim_q.push_back(mk_one(64'h7fff_ffff_ffff_ffff, 4, 1));
    stim_q.push_back(mk_one(64'h0, 5, -1));
    stim_q.push_back(mk_ramp(64'h55, 3));
    stim_q.push_back(mk_ramp(64'h4000_0000, -1000));
    stim_q.push_back(mk_ramp(64'h99, 100000));
    stim_q.push_back(mk_ramp(64'h1, 64'sh1_0000_0000));
    for (int i = 0; i < 160; i++) stim_q.push_back(mk_rand(i % 4));
    for (int i = 0; i < 20; i++) stim_q.push_back('0);

    repeat (3) @(negedge clk);
    chk(c_out_valid == 1'b0, "R10", "c_out_valid in reset", LW'(c_out_valid), '0);
    chk(c_in_ready == 1'b0, "R10", "c_in_ready in reset", LW'(c_in_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(c_in_ready == 1'b0, "R10", "c_in_ready right after release", LW'(c_in_ready), '0);
    repeat (3) @(negedge clk);

    for (int cyc = 0; cyc < 50000; cyc++) begin
      if (stim_q.size() == 0 && !m_vld) break;
      @(negedge clk);
      chk(c_out_valid == m_vld, "R1", "c_out_valid", LW'(c_out_valid), LW'(m_vld));
      if (m_vld) begin
        chk(c_out_tag == m_tag, "R3", "tag", LW'(c_out_tag), LW'(m_tag));
        chk(c_out_size == m_size, "R6", "size", LW'(c_out_size), LW'(m_size));
        chk(c_out_payload == m_pl, (m_tag == 2'd3) ? "R4" : "R5", "payload", c_out_payload, m_pl);
        chk(d_out_line == m_line, (m_tag == 2'd3) ? "R9" : "R8", "decoded line", d_out_line, m_line);
        if (m_line == '0)
          chk(c_out_tag == 2'd0 && c_out_size == 7'd16, "R7", "zero line tag/size",
              LW'({c_out_tag, c_out_size}), LW'({2'd0, 7'd16}));
      end
      if (prev_stall)
        chk(c_out_valid && c_out_payload == prev_pl && c_out_tag == prev_tag && c_out_size == prev_size,
            "R2", "hold under stall", c_out_payload, prev_pl);

      d_out_ready = ($urandom_range(0, 3) != 0);
      if (stim_q.size() > 0 && $urandom_range(0, 4) != 0) begin
        c_in_valid = 1'b1; c_in_line = stim_q[0];
      end else begin
        c_in_valid = 1'b0; c_in_line = {16{$urandom}};
      end
      #1;
      chk(c_in_ready == (!m_vld || d_out_ready), "R1", "c_in_ready",
          LW'(c_in_ready), LW'(!m_vld || d_out_ready));
      chk(d_out_valid == c_out_valid && d_in_ready == d_out_ready, "R8", "decoder handshake",
          LW'({d_out_valid, d_in_ready}), LW'({c_out_valid, d_out_ready}));
      acc = c_in_valid && (!m_vld || d_out_ready);
      prev_stall = m_vld && !d_out_ready;
      prev_pl = c_out_payload; prev_tag = c_out_tag; prev_size = c_out_size;
      if (m_vld && d_out_ready) m_vld = 0;
      if (acc) begin
        m_line = stim_q.pop_front();
        ref_enc(m_line, m_tag, m_size, m_pl);
        m_vld = 1;
      end
    end

    if (stim_q.size() != 0 || m_vld) begin
      errors++;
      $display("FAIL R1 stream incomplete actual=%0d expected=0", stim_q.size());
    end
    summary();
  end
endmodule